// File: doc/BRIEF.md
# RAS-only DRAM refresh controller

This block keeps a two-bank DRAM array refreshed without help from the processor. A free-running interval timer raises a refresh request at a fixed period. The request is held in one pending flag. When no memory access is in flight, the controller takes over the row address lines and runs a RAS-only cycle. In that cycle it releases the low byte of the normal address multiplexer and drives its own row number onto those lines. It pulls both bank RAS strobes low together and keeps every CAS strobe high. Each completed cycle moves the row counter on by one, so all 256 rows are refreshed in turn and the sequence then starts again at row 0.

The surrounding memory controller reads `ref_hold` and must not start a new access while it is high. An access that is already running is allowed to finish, and the refresh starts on the first clock after it ends. Outside refresh, the RAS and CAS strobes requested by the access logic pass straight through. All strobes are active-low. Reset is synchronous and active-high. The interface is plain control: there is no data stream and so no back-pressure.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, both RAS outputs and all CAS outputs follow the access inputs, `ref_hold`, `mux_lo_hiz` and `ref_row_oe` are low, and `ref_row` is 0.
- R2: The interval timer raises a request every INTERVAL clocks, whether or not earlier requests have been served. The first request comes INTERVAL clocks after reset is released.
- R3: A request that arrives while an earlier one is still pending merges into it, so it causes no extra refresh cycle.
- R4: `ref_hold` is high whenever a request is pending or a refresh cycle is running.
- R5: A pending request starts a refresh on the next clock edge at which `acc_active` is low. While `acc_active` is high, the refresh is deferred.
- R6: A refresh cycle takes RAS_CYCLES+2 clocks: one takeover clock with RAS high, RAS_CYCLES clocks with RAS low, and one precharge clock with RAS high.
- R7: During a refresh cycle, `ras_n` is 2'b00 in the strobe clocks and 2'b11 in the other two clocks, and `cas_n` is all ones throughout.
- R8: `mux_lo_hiz` and `ref_row_oe` are both high for exactly the clocks of a refresh cycle, and low at all other times.
- R9: `ref_row` holds the row being refreshed. It increments by one after each refresh and wraps from 255 to 0.
- R10: When no refresh is running, `ras_n` equals `acc_ras_n` and `cas_n` equals `acc_cas_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_active | input | 1 | A memory access is in progress |
| acc_ras_n | input | NBANK | RAS strobes from the access logic (active-low) |
| acc_cas_n | input | CAS_W | CAS strobes from the access logic (active-low) |
| ref_hold | output | 1 | Refresh pending or running; no new access may start |
| mux_lo_hiz | output | 1 | Puts the low byte of the address multiplexer in high impedance |
| ref_row_oe | output | 1 | Enables the refresh row driver onto the low address byte |
| ref_row | output | ROW_W | Row address being refreshed |
| ras_n | output | NBANK | RAS strobes to the DRAM banks (active-low) |
| cas_n | output | CAS_W | CAS strobes to the DRAM banks (active-low) |

## Verification
The assertions assume that the access logic honours `ref_hold`. In particular, they assume that `acc_active` never rises in a clock in which `ref_hold` was already high. The stimulus keeps to this by starting an access only on a falling edge at which `ref_hold` reads low. Access lengths are kept short compared with the interval, except for one deliberately long access that spans two requests and so exercises merging and deferral.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    RS_IDLE    = 2'd0,
    RS_TAKE    = 2'd1,
    RS_STROBE  = 2'd2,
    RS_PRECHG  = 2'd3
  } rs_state_t;
endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int INTERVAL = 312
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= RELOAD;
    else if (cnt_q == '0) cnt_q <= RELOAD;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);

  // R2: counter reloads after each request and never leaves its range
  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == RELOAD));
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RELOAD);
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic acc_active,
  input  logic seq_idle,
  output logic pending,
  output logic start
);
  logic pend_q;

  assign start   = pend_q & seq_idle & ~acc_active;
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= tick | (pend_q & ~start);
  end

  // R2: every request is captured
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    tick |=> pend_q);
  // R3: an unserved request stays as a single flag
  a_r3_hold_flag: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !start) |=> pend_q);
  // R5: an access in flight defers the refresh start
  a_r5_defer: assert property (@(posedge clk) disable iff (rst)
    (pend_q && acc_active) |=> pend_q);
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int RAS_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic idle,
  output logic own,
  output logic strobe,
  output logic done
);
  localparam int RW = (RAS_CYCLES > 1) ? $clog2(RAS_CYCLES) : 1;
  localparam logic [RW-1:0] RLOAD = RW'(RAS_CYCLES - 1);

  rs_state_t state_q, state_d;
  logic [RW-1:0] rcnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:   if (start) state_d = RS_TAKE;
      RS_TAKE:   state_d = RS_STROBE;
      RS_STROBE: if (rcnt_q == '0) state_d = RS_PRECHG;
      RS_PRECHG: state_d = RS_IDLE;
      default:   state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_IDLE;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == RS_TAKE)                    rcnt_q <= RLOAD;
      else if (state_q == RS_STROBE && rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
    end
  end

  assign idle   = (state_q == RS_IDLE);
  assign own    = (state_q != RS_IDLE);
  assign strobe = (state_q == RS_STROBE);
  assign done   = (state_q == RS_PRECHG);

  // R6: fixed ordering of the refresh phases
  a_r6_take_next: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_TAKE) |=> (state_q == RS_STROBE));
  a_r6_pre_next: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_PRECHG) |=> (state_q == RS_IDLE));
  a_r6_strobe_len: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_STROBE && rcnt_q != '0) |=> (state_q == RS_STROBE));
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst)          row_q <= '0;
    else if (advance) row_q <= row_q + 1'b1;
  end

  assign row = row_q;

  // R9: one step per completed refresh, wrapping at the top
  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    advance |=> (row_q == $past(row_q) + 1'b1));
  a_r9_steady: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int INTERVAL   = 312,
  parameter int RAS_CYCLES = 3,
  parameter int NBANK      = 2,
  parameter int CAS_W      = 4,
  parameter int ROW_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_active,
  input  logic [NBANK-1:0] acc_ras_n,
  input  logic [CAS_W-1:0] acc_cas_n,
  output logic             ref_hold,
  output logic             mux_lo_hiz,
  output logic             ref_row_oe,
  output logic [ROW_W-1:0] ref_row,
  output logic [NBANK-1:0] ras_n,
  output logic [CAS_W-1:0] cas_n
);
  logic tick, pending, start, idle, own, strobe, done;

  refresh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  refresh_arbiter u_arb (
    .clk(clk), .rst(rst), .tick(tick), .acc_active(acc_active),
    .seq_idle(idle), .pending(pending), .start(start)
  );

  refresh_seq #(.RAS_CYCLES(RAS_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .idle(idle),
    .own(own), .strobe(strobe), .done(done)
  );

  refresh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .advance(done), .row(ref_row)
  );

  assign ref_hold   = pending | own;
  assign mux_lo_hiz = own;
  assign ref_row_oe = own;

  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    assign ras_n[b] = own ? ~strobe : acc_ras_n[b];
  end

  for (genvar c = 0; c < CAS_W; c++) begin : g_cas
    assign cas_n[c] = own | acc_cas_n[c];
  end

  // R7: with refresh owning the lines, banks strobe together and CAS stays idle
  a_r7_banks_together: assert property (@(posedge clk) disable iff (rst)
    ref_row_oe |-> (ras_n == '0 || ras_n == '1));
  a_r7_no_cas: assert property (@(posedge clk) disable iff (rst)
    (ref_row_oe && ras_n == '0) |-> (cas_n == '1));
  // R4: refresh ownership is always visible on the hold output
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    ref_row_oe |-> ref_hold);
  // R5: no refresh begins while an access is in flight
  a_r5_no_start: assert property (@(posedge clk) disable iff (rst)
    (!ref_row_oe && acc_active) |=> !ref_row_oe);
endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 24;
  localparam int RAS_CYCLES = 3;
  localparam int NBANK      = 2;
  localparam int CAS_W      = 4;
  localparam int ROW_W      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_active = 1'b0;
  logic [NBANK-1:0] acc_ras_n = '1;
  logic [CAS_W-1:0] acc_cas_n = '1;
  logic ref_hold, mux_lo_hiz, ref_row_oe;
  logic [ROW_W-1:0] ref_row;
  logic [NBANK-1:0] ras_n;
  logic [CAS_W-1:0] cas_n;

  dram_refresh_ctrl #(.INTERVAL(INTERVAL), .RAS_CYCLES(RAS_CYCLES),
    .NBANK(NBANK), .CAS_W(CAS_W), .ROW_W(ROW_W)) i_dram_refresh_ctrl (
    .clk(clk), .rst(rst), .acc_active(acc_active), .acc_ras_n(acc_ras_n),
    .acc_cas_n(acc_cas_n), .ref_hold(ref_hold), .mux_lo_hiz(mux_lo_hiz),
    .ref_row_oe(ref_row_oe), .ref_row(ref_row), .ras_n(ras_n), .cas_n(cas_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference: timer count, pending flag, phase, strobe count, row
  int m_tcnt, m_ph, m_rc, m_row, cyc;
  bit m_pend, acc_at_edge;
  always @(posedge clk) begin
    bit tk, st;
    cyc++;
    acc_at_edge = acc_active;
    if (rst) begin
      m_tcnt = INTERVAL - 1; m_pend = 0; m_ph = 0; m_rc = 0; m_row = 0;
    end else begin
      tk = (m_tcnt == 0);
      m_tcnt = tk ? INTERVAL - 1 : m_tcnt - 1;
      st = m_pend && m_ph == 0 && !acc_active;
      m_pend = tk || (m_pend && !st);
      case (m_ph)
        0: if (st) m_ph = 1;
        1: begin m_ph = 2; m_rc = RAS_CYCLES - 1; end
        2: if (m_rc == 0) m_ph = 3; else m_rc--;
        default: begin m_ph = 0; m_row = (m_row + 1) % 256; end
      endcase
    end
  end

  // per-cycle comparison and event checks, a quarter period after the falling edge
  bit quiet = 0, prev_oe = 0;
  int last_start = -1, refreshes = 0, wraps = 0, exp_row = 0;
  always @(negedge clk) begin
    int e_ras, e_cas;
    #(CLK_PERIOD/4);
    if (!rst) begin
      e_ras = (m_ph == 2) ? 0 : (m_ph != 0) ? (1 << NBANK) - 1 : int'(acc_ras_n);
      e_cas = (m_ph != 0) ? (1 << CAS_W) - 1 : int'(acc_cas_n);
      chk(ref_hold == (m_pend || m_ph != 0), "R4 hold", ref_hold, m_pend || m_ph != 0);
      chk(mux_lo_hiz == (m_ph != 0), "R8 mux_lo_hiz", mux_lo_hiz, m_ph != 0);
      chk(ref_row_oe == (m_ph != 0), "R8 ref_row_oe", ref_row_oe, m_ph != 0);
      chk(int'(ref_row) == m_row, "R9 row", ref_row, m_row);
      chk(int'(ras_n) == e_ras, (m_ph != 0) ? "R6/R7 ras_n" : "R10 ras_n", ras_n, e_ras);
      chk(int'(cas_n) == e_cas, (m_ph != 0) ? "R7 cas_n" : "R10 cas_n", cas_n, e_cas);
      if (ref_row_oe && !prev_oe) begin
        chk(acc_at_edge == 0, "R5 start during access", acc_at_edge, 0);
        chk(int'(ref_row) == exp_row, "R9 row sequence", ref_row, exp_row);
        if (ref_row == 8'd255) wraps++;
        exp_row = (exp_row + 1) % 256;
        if (quiet && last_start >= 0)
          chk(cyc - last_start == INTERVAL, "R2 period", cyc - last_start, INTERVAL);
        last_start = cyc;
        refreshes++;
      end
      prev_oe = ref_row_oe;
    end
  end

  task automatic do_access(input int len);
    acc_active = 1'b1;
    acc_ras_n  = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01;
    acc_cas_n  = CAS_W'($urandom_range(0, (1 << CAS_W) - 2));
    repeat (len) @(negedge clk);
    acc_active = 1'b0;
    acc_ras_n  = '1;
    acc_cas_n  = '1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int row_before;
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4);
    // R1: reset state
    chk(ref_hold == 0 && ref_row_oe == 0 && mux_lo_hiz == 0, "R1 control idle",
        {ref_hold, ref_row_oe, mux_lo_hiz}, 0);
    chk(ref_row == 0, "R1 row zero", ref_row, 0);
    chk(ras_n == 2'b11 && cas_n == 4'hF, "R1 strobes high", {ras_n, cas_n}, 6'h3F);
    @(negedge clk); rst = 1'b0;

    // R2: undisturbed period
    quiet = 1;
    repeat (5 * INTERVAL + 2) @(negedge clk);
    quiet = 0;
    chk(refreshes == 5, "R2 count in quiet span", refreshes, 5);

    // R3/R5: one long access spans two requests
    while (!ref_row_oe) @(negedge clk);
    while (ref_row_oe) @(negedge clk);
    row_before = ref_row;
    do_access(2 * INTERVAL + 2);
    repeat (2 * (RAS_CYCLES + 2) + 2) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(int'(ref_row) == (row_before + 1) % 256, "R3 merged requests",
        ref_row, (row_before + 1) % 256);
    chk(ref_hold == 0, "R3 no second refresh queued", ref_hold, 0);

    // random traffic until the row counter has wrapped
    while (refreshes < 270) begin
      @(negedge clk);
      if (!ref_hold && $urandom_range(0, 9) < 4) do_access($urandom_range(1, 6));
    end
    chk(wraps >= 1, "R9 wrap 255 to 0", wraps, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule